// File: doc/BRIEF.md
# Embedded Erase Busy Timer and Poll Status

This block sits beside the command sequencer of a NOR-style flash device model. It measures how long an embedded chip erase or sector erase keeps the device busy, counting clock cycles. It also keeps the status byte that software polls while it waits. When an erase begins, the status byte is cleared. Each status read inverts bit 6, so two polls in a row return different values. When the erase time runs out, bit 7 is inverted to mark completion.

At completion the block issues a one-cycle pulse together with a routing flag. The flag tells the sequencer where to go next. If unlock bypass was active, it returns to the state that waits for a bypass command. Otherwise it returns to plain read mode.

A program operation finishes at once. It loads the status byte with the complement of bit 7 of the written data. While an erase is busy, bus writes and program events are blocked, and new erase start pulses are ignored.

Top module: `erase_poll_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves status at 0x00, busy low, done_pulse low and done_to_bypass low.
- R2: A start pulse taken while idle clears the status byte to 0x00 and raises busy at the next edge. When chip_erase_go and sector_erase_go are both high, the chip erase is the one started.
- R3: Busy stays high for exactly CHIP_CYCLES clock cycles after a chip erase start, and for exactly SECTOR_CYCLES cycles after a sector erase start. Busy falls on the same edge at which done_pulse rises, and done_pulse lasts one cycle.
- R4: On the completion edge, status bit 7 (value 0x80) is inverted and the other bits are kept.
- R5: Each cycle with status_rd high inverts status bit 6 (value 0x40) at the next edge. This inversion is applied on top of whatever any other event loads in that same cycle.
- R6: While done_pulse is high, done_to_bypass equals the value bypass_on had in the last busy cycle. 1 means return to the bypass-command state; 0 means return to read mode.
- R7: A prog_done taken while idle and with no start pulse sets status to 0x7F when prog_data bit 7 is 1, and to 0xFF when it is 0. Busy is not raised.
- R8: While busy, wr_pass is held low and prog_done leaves the status byte untouched. While idle, wr_pass follows bus_wr in the same cycle.
- R9: A start pulse that arrives while busy is ignored. The status byte is not cleared and the completion edge does not move.
- R10: When status_rd is high in the last busy cycle, both bit 7 and bit 6 are inverted on the completion edge (status XOR 0xC0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_erase_go | input | 1 | Start pulse for a chip erase |
| sector_erase_go | input | 1 | Start pulse for a sector erase |
| status_rd | input | 1 | Strobe for a status byte read |
| prog_done | input | 1 | Program operation done event |
| prog_data | input | 8 | Data byte of the program operation |
| bypass_on | input | 1 | Unlock bypass mode active |
| bus_wr | input | 1 | Bus write strobe from the host side |
| status | output | 8 | Poll status byte |
| busy | output | 1 | Erase in progress |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_to_bypass | output | 1 | Return state: 1 = bypass-command wait, 0 = read mode |
| wr_pass | output | 1 | bus_wr passed through only while idle |

## Verification
The completion edge and a status poll can fall in the same cycle. On that edge both bit 7 and bit 6 change together. The bench provokes this by counting idle cycles after a sector erase start and placing a status_rd strobe in the last busy cycle. The per-clock reference model must then expect status XOR 0xC0.

A second overlap is a start pulse or program event that arrives during the busy window, or on the completion cycle itself. The bench judges it by checking that the status byte and the completion edge are unchanged.

// File: rtl/erase_poll_pkg.sv
package erase_poll_pkg;

  typedef enum logic [1:0] {
    ER_NONE   = 2'd0,
    ER_SECTOR = 2'd1,
    ER_CHIP   = 2'd2
  } erase_kind_e;

  localparam logic [7:0] ST_CLEARED = 8'h00;
  localparam logic [7:0] ST_DONE_BIT = 8'h80;
  localparam logic [7:0] ST_POLL_BIT = 8'h40;

  // Status after an immediate program: complement of data bit 7 spread over the byte
  function automatic logic [7:0] prog_status(input logic [7:0] data);
    return ~(data & ST_DONE_BIT);
  endfunction

  // Apply the poll toggle on top of a status value
  function automatic logic [7:0] poll_flip(input logic [7:0] s, input logic rd);
    return rd ? (s ^ ST_POLL_BIT) : s;
  endfunction

  // Chip erase wins when both start pulses are present
  function automatic erase_kind_e pick_kind(input logic chip, input logic sector);
    if (chip)        return ER_CHIP;
    else if (sector) return ER_SECTOR;
    else             return ER_NONE;
  endfunction

endpackage

// File: rtl/erase_countdown.sv
module erase_countdown
  import erase_poll_pkg::*;
#(
  parameter int CHIP_CYCLES   = 1000000000,
  parameter int SECTOR_CYCLES = 100000000
) (
  input  logic        clk,
  input  logic        rst,
  input  erase_kind_e req_kind,
  output logic        busy,
  output logic        start_taken,
  output logic        last_cycle,
  output logic        done_pulse
);
  localparam int MAX_CYCLES = (CHIP_CYCLES > SECTOR_CYCLES) ? CHIP_CYCLES : SECTOR_CYCLES;
  localparam int CNT_W      = (MAX_CYCLES > 1) ? $clog2(MAX_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] load_value(input erase_kind_e k);
    if (k == ER_CHIP) return CNT_W'(CHIP_CYCLES - 1);
    else              return CNT_W'(SECTOR_CYCLES - 1);
  endfunction

  assign start_taken = (req_kind != ER_NONE) && !busy;
  assign last_cycle  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      busy       <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= last_cycle;
      if (start_taken) begin
        cnt  <= load_value(req_kind);
        busy <= 1'b1;
      end else if (last_cycle) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_cycle) |=> (busy && cnt == $past(cnt) - CNT_W'(1))) else $error("AST_NO_RESTART"); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    last_cycle |=> (!busy && done_pulse)) else $error("AST_BUSY_ENDS"); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse) else $error("AST_DONE_ONE"); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_taken |=> busy) else $error("AST_START_BUSY"); // R2

endmodule

// File: rtl/poll_status_reg.sv
module poll_status_reg
  import erase_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_evt,
  input  logic       finish_evt,
  input  logic       prog_evt,
  input  logic [7:0] prog_data,
  input  logic       rd,
  output logic [7:0] status
);
  logic [7:0] base;

  always_comb begin
    base = status;
    if (finish_evt)     base = status ^ ST_DONE_BIT;
    else if (clear_evt) base = ST_CLEARED;
    else if (prog_evt)  base = prog_status(prog_data);
  end

  always_ff @(posedge clk) begin
    if (rst) status <= ST_CLEARED;
    else     status <= poll_flip(base, rd);
  end

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
    (clear_evt && !rd) |=> (status == 8'h00)) else $error("AST_CLEAR_ON_START"); // R2
  AST_POLL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (rd && !clear_evt && !finish_evt && !prog_evt) |=> (status == ($past(status) ^ 8'h40))) else $error("AST_POLL_TOGGLE"); // R5
  AST_DONE_B7: assert property (@(posedge clk) disable iff (rst)
    (finish_evt && !rd) |=> (status == ($past(status) ^ 8'h80))) else $error("AST_DONE_B7"); // R4
  AST_DONE_AND_POLL: assert property (@(posedge clk) disable iff (rst)
    (finish_evt && rd) |=> (status == ($past(status) ^ 8'hC0))) else $error("AST_DONE_AND_POLL"); // R10
  AST_PROG_STATUS: assert property (@(posedge clk) disable iff (rst)
    (prog_evt && !clear_evt && !rd) |=> (status[6:0] == 7'h7F && status[7] == !$past(prog_data[7]))) else $error("AST_PROG_STATUS"); // R7
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(finish_evt && (clear_evt || prog_evt))) else $error("AST_EVT_EXCL"); // R8

endmodule

// File: rtl/exit_router.sv
module exit_router (
  input  logic clk,
  input  logic rst,
  input  logic last_cycle,
  input  logic done_pulse,
  input  logic bypass_on,
  input  logic busy,
  input  logic bus_wr,
  output logic done_to_bypass,
  output logic wr_pass
);
  always_ff @(posedge clk) begin
    if (rst)             done_to_bypass <= 1'b0;
    else if (last_cycle) done_to_bypass <= bypass_on;
  end

  assign wr_pass = bus_wr && !busy;

  AST_ROUTE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (done_to_bypass == $past(bypass_on))) else $error("AST_ROUTE"); // R6
  AST_ROUTE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !busy) else $error("AST_ROUTE_IDLE"); // R3

endmodule

// File: rtl/erase_poll_tracker.sv
module erase_poll_tracker
  import erase_poll_pkg::*;
#(
  parameter int CHIP_CYCLES   = 1000000000,
  parameter int SECTOR_CYCLES = 100000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chip_erase_go,
  input  logic       sector_erase_go,
  input  logic       status_rd,
  input  logic       prog_done,
  input  logic [7:0] prog_data,
  input  logic       bypass_on,
  input  logic       bus_wr,
  output logic [7:0] status,
  output logic       busy,
  output logic       done_pulse,
  output logic       done_to_bypass,
  output logic       wr_pass
);
  erase_kind_e req_kind;
  logic        start_taken;
  logic        last_cycle;
  logic        prog_taken;

  assign req_kind   = pick_kind(chip_erase_go, sector_erase_go);
  assign prog_taken = prog_done && !busy && !start_taken;

  erase_countdown #(
    .CHIP_CYCLES  (CHIP_CYCLES),
    .SECTOR_CYCLES(SECTOR_CYCLES)
  ) u_count (
    .clk        (clk),
    .rst        (rst),
    .req_kind   (req_kind),
    .busy       (busy),
    .start_taken(start_taken),
    .last_cycle (last_cycle),
    .done_pulse (done_pulse)
  );

  poll_status_reg u_stat (
    .clk       (clk),
    .rst       (rst),
    .clear_evt (start_taken),
    .finish_evt(last_cycle),
    .prog_evt  (prog_taken),
    .prog_data (prog_data),
    .rd        (status_rd),
    .status    (status)
  );

  exit_router u_route (
    .clk           (clk),
    .rst           (rst),
    .last_cycle    (last_cycle),
    .done_pulse    (done_pulse),
    .bypass_on     (bypass_on),
    .busy          (busy),
    .bus_wr        (bus_wr),
    .done_to_bypass(done_to_bypass),
    .wr_pass       (wr_pass)
  );

  AST_BUSY_BLOCKS_PROG: assert property (@(posedge clk) disable iff (rst)
    (busy && prog_done && !last_cycle && !status_rd) |=> $stable(status)) else $error("AST_BUSY_BLOCKS_PROG"); // R8

endmodule

// File: tb/sim_erase_poll_tracker.sv
module sim_erase_poll_tracker;
  localparam int CHIP_N = 40;
  localparam int SECT_N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_go = 0, sect_go = 0, rd = 0, pd = 0, byp = 0, wr = 0;
  logic [7:0] pdat = 8'h00;
  logic [7:0] status;
  logic busy, done_pulse, done_to_bypass, wr_pass;

  int n_checks = 0;
  int n_fail = 0;
  bit summary_done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  erase_poll_tracker #(.CHIP_CYCLES(CHIP_N), .SECTOR_CYCLES(SECT_N)) u0 (
    .clk(clk), .rst(rst), .chip_erase_go(chip_go), .sector_erase_go(sect_go),
    .status_rd(rd), .prog_done(pd), .prog_data(pdat), .bypass_on(byp), .bus_wr(wr),
    .status(status), .busy(busy), .done_pulse(done_pulse),
    .done_to_bypass(done_to_bypass), .wr_pass(wr_pass));

  // Behavioural reference: remaining cycles, status byte, route flag
  int   m_left = 0;
  logic [7:0] m_stat = 8'h00;
  logic m_done = 0, m_route = 0;

  always @(posedge clk) begin
    logic [7:0] nxt;
    if (rst) begin
      m_left = 0; m_stat = 8'h00; m_done = 0; m_route = 0;
    end else begin
      nxt = m_stat;
      m_done = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          nxt[7] = ~nxt[7];
          m_done = 1;
          m_route = byp;
        end
      end else if (chip_go || sect_go) begin
        m_left = chip_go ? CHIP_N : SECT_N;
        nxt = 8'h00;
      end else if (pd) begin
        nxt = pdat[7] ? 8'h7F : 8'hFF;
      end
      if (rd) nxt[6] = ~nxt[6];
      m_stat = nxt;
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("status", status, m_stat);
    chk("busy", {7'd0, busy}, {7'd0, (m_left > 0)});
    chk("done_pulse", {7'd0, done_pulse}, {7'd0, m_done});
    chk("wr_pass", {7'd0, wr_pass}, {7'd0, wr && (m_left == 0)});
    if (m_done) chk("done_to_bypass", {7'd0, done_to_bypass}, {7'd0, m_route});
  endtask

  task automatic step(input logic c, input logic s, input logic r, input logic p,
                      input logic [7:0] d, input logic b, input logic w);
    @(negedge clk);
    compare();
    chip_go = c; sect_go = s; rd = r; pd = p; pdat = d; byp = b; wr = w;
  endtask

  task automatic idle(input int n, input logic b);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, b, 0);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);
    chk("R1 done after reset", {7'd0, done_pulse}, 8'h00);
    chk("R1 route after reset", {7'd0, done_to_bypass}, 8'h00);
    rst = 0;

    tag = "R5"; // polls alternate bit 6 while idle
    step(0, 0, 1, 0, 8'h00, 0, 0);
    step(0, 0, 1, 0, 8'h00, 0, 0);
    step(0, 0, 1, 0, 8'h00, 0, 1);
    idle(1, 0);

    tag = "R7"; // program sets complement of data bit 7
    step(0, 0, 0, 1, 8'hA5, 0, 0);
    step(0, 0, 0, 1, 8'h3C, 0, 0);
    step(0, 0, 1, 1, 8'hFF, 0, 0);
    idle(2, 0);

    tag = "R2"; // sector erase, no bypass, with polls
    step(0, 1, 0, 0, 8'h00, 0, 0);
    tag = "R3";
    for (int i = 0; i < SECT_N + 2; i++) step(0, 0, (i % 3) == 1, 0, 8'h00, 0, 0);
    tag = "R4";
    idle(2, 0);

    tag = "R6"; // chip erase with bypass, blocked traffic while busy
    step(0, 0, 0, 1, 8'h00, 1, 0);
    step(1, 0, 0, 0, 8'h00, 1, 0);
    tag = "R8";
    step(0, 0, 0, 1, 8'h80, 1, 1);
    step(0, 0, 1, 0, 8'h00, 1, 1);
    tag = "R9";
    step(0, 1, 0, 0, 8'h00, 1, 0);
    step(1, 0, 0, 0, 8'h00, 1, 0);
    tag = "R6";
    idle(CHIP_N, 1);
    idle(2, 0);

    tag = "R2"; // both starts: chip wins
    step(1, 1, 0, 0, 8'h00, 0, 0);
    tag = "R3";
    idle(CHIP_N + 2, 0);

    tag = "R10"; // poll on the completion cycle
    step(0, 1, 1, 0, 8'h00, 1, 0);
    idle(SECT_N - 1, 1);
    step(0, 0, 1, 0, 8'h00, 1, 0);
    idle(3, 0);

    tag = "R9"; // start on the completion cycle is ignored
    step(0, 1, 0, 0, 8'h00, 0, 0);
    idle(SECT_N - 1, 0);
    step(1, 0, 0, 1, 8'h00, 0, 1);
    idle(3, 0);

    tag = "R1"; // reset during busy
    step(1, 0, 0, 0, 8'h00, 0, 0);
    idle(5, 0);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 status after mid-erase reset", status, 8'h00);
    chk("R1 busy after mid-erase reset", {7'd0, busy}, 8'h00);
    rst = 0;
    idle(3, 0);
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule